// File: doc/BRIEF.md
# Output Driver Impedance Update Scheduler

This block decides when a background recalibration of the output driver impedance may be put into effect. An external comparator produces a fresh impedance code all the time. The scheduler passes that code to the drivers only in a cycle in which the outputs are not being driven, and no more often than a fixed minimum interval. The outputs are a one-cycle update strobe, the impedance code that is currently in force, and a flag that rises once the drivers have seen enough quiet cycles after power-up to be considered calibrated.

The interval timer advances on every clock, whatever kind of cycle is in progress. Once the interval has elapsed, the timer holds at its limit and waits. The strobe then fires in the first cycle whose activity flag is low. The strobe is a combinational function of the current cycle's activity flag and registered state, so the update lands inside the quiet cycle itself. The comparator code is a plain level with no handshake and is sampled at the clock edge that closes a strobe cycle. The interface has no back-pressure: the consumer of the strobe must accept it in the cycle in which it appears.

Top module: `zimp_update_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the interval timer, the quiet-cycle count and the calibrated flag, and loads `code_out` with `RESET_CODE`. While reset is held, `upd_stb` and `cal_done` are low.
- R2: Two strobes are at least `GAP_CYCLES` clock cycles apart (strobe cycles k and m satisfy m - k >= GAP_CYCLES). Reset counts as an update in the cycle just before release, so the earliest first strobe falls in the cycle that follows the (GAP_CYCLES-1)-th clock edge after release.
- R3: `upd_stb` is never high in a cycle in which `out_active` is high.
- R4: Once the interval has elapsed, `upd_stb` goes high in the same cycle as the first cycle with `out_active` low. This holds even after a run of busy cycles longer than the interval.
- R5: Each strobe lasts exactly one clock cycle.
- R6: At the edge that ends a strobe cycle, `code_out` takes the value that `code_in` held in that cycle. At every other edge outside reset, `code_out` keeps its value.
- R7: `cal_done` goes high after `CAL_CYCLES` clock edges (counted since reset, not necessarily consecutive) have sampled `out_active` low. It then stays high until the next reset.
- R8: The interval timer advances on busy cycles as well as on quiet ones, so busy cycles count toward the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| out_active | input | 1 | High in a cycle in which the output drivers are enabled (a read) |
| code_in | input | CODE_W | Impedance code from the external comparator, a free-running level |
| upd_stb | output | 1 | One-cycle strobe: the new code is applied in this cycle |
| code_out | output | CODE_W | Impedance code currently in force |
| cal_done | output | 1 | Enough quiet cycles have elapsed since reset for optimal impedance |

## Verification
A wrong count in the interval timer shows up at the ports within one interval. The strobe then appears early, late, or twice in a row, and a timer that fails to advance during busy cycles moves the first strobe after a read burst. A wrong load condition on the code register is visible one cycle later as a changed `code_out` with no strobe before it, or as a stale code after a strobe. The quiet-cycle counter is only visible at the end of its count, so an error there shows up as `cal_done` rising one or more cycles away from the `CAL_CYCLES`-th quiet edge, or falling again afterwards.

// File: rtl/zimp_pkg.sv
package zimp_pkg;
  // Default shape of the scheduler
  localparam int unsigned ZIMP_GAP_DEF  = 32;
  localparam int unsigned ZIMP_CAL_DEF  = 1024;
  localparam int unsigned ZIMP_CODE_DEF = 6;

  // Timer phase seen from outside
  typedef enum logic [0:0] {
    TMR_COUNTING = 1'b0,
    TMR_WAITING  = 1'b1
  } tmr_phase_e;
endpackage

// File: rtl/zimp_gap_timer.sv
module zimp_gap_timer #(
  parameter int unsigned GAP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic out_active,
  output zimp_pkg::tmr_phase_e phase,
  output logic fire
);
  localparam int unsigned CNT_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] elapsed;

  assign phase = (elapsed == LIMIT) ? zimp_pkg::TMR_WAITING : zimp_pkg::TMR_COUNTING;
  assign fire  = (phase == zimp_pkg::TMR_WAITING) && !out_active && !rst;

  // Advances on every clock; clears on an issued update; holds at the limit
  always_ff @(posedge clk) begin
    if (rst)                 elapsed <= '0;
    else if (fire)           elapsed <= '0;
    else if (elapsed != LIMIT) elapsed <= elapsed + CNT_W'(1);
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    elapsed <= LIMIT);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/zimp_cal_tracker.sv
module zimp_cal_tracker #(
  parameter int unsigned CAL_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic out_active,
  output logic cal_done
);
  localparam int unsigned CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] CAL_END = CW'(CAL_CYCLES);

  logic [CW-1:0] quiet_n;

  always_ff @(posedge clk) begin
    if (rst)                                   quiet_n <= '0;
    else if (!out_active && quiet_n != CAL_END) quiet_n <= quiet_n + CW'(1);
  end

  assign cal_done = (quiet_n == CAL_END);

  a_r7_cal_sticky: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> cal_done);

  a_r7_cal_rise_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done) |-> $past(!out_active));
endmodule

// File: rtl/zimp_code_latch.sv
module zimp_code_latch #(
  parameter int unsigned CODE_W = 6,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)       code_q <= RESET_CODE;
    else if (load) code_q <= code_in;
  end

  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(code_q));
endmodule

// File: rtl/zimp_update_sched.sv
module zimp_update_sched #(
  parameter int unsigned GAP_CYCLES = zimp_pkg::ZIMP_GAP_DEF,
  parameter int unsigned CAL_CYCLES = zimp_pkg::ZIMP_CAL_DEF,
  parameter int unsigned CODE_W     = zimp_pkg::ZIMP_CODE_DEF,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(32)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_active,
  input  logic [CODE_W-1:0] code_in,
  output logic              upd_stb,
  output logic [CODE_W-1:0] code_out,
  output logic              cal_done
);
  zimp_pkg::tmr_phase_e phase;
  logic fire;

  zimp_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .out_active(out_active), .phase(phase), .fire(fire)
  );

  zimp_code_latch #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_latch (
    .clk(clk), .rst(rst), .load(fire), .code_in(code_in), .code_q(code_out)
  );

  zimp_cal_tracker #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst(rst), .out_active(out_active), .cal_done(cal_done)
  );

  assign upd_stb = fire;

  // R4: a waiting timer never lets a quiet cycle pass without an update
  a_r4_no_missed_idle: assert property (@(posedge clk) disable iff (rst)
    (phase == zimp_pkg::TMR_WAITING && !out_active) |=> phase == zimp_pkg::TMR_COUNTING);
endmodule

// File: tb/zimp_update_sched_tb.sv
module zimp_update_sched_tb;
  localparam int GAP = 32;
  localparam int CAL = 1024;
  localparam int CW  = 6;
  localparam logic [CW-1:0] RCODE = 6'd32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_active = 1'b1;
  logic [CW-1:0] code_in = '0;
  logic upd_stb;
  logic [CW-1:0] code_out;
  logic cal_done;

  always #2.5 clk = ~clk;

  zimp_update_sched #(.GAP_CYCLES(GAP), .CAL_CYCLES(CAL), .CODE_W(CW), .RESET_CODE(RCODE)) u_dut (
    .clk(clk), .rst(rst), .out_active(out_active), .code_in(code_in),
    .upd_stb(upd_stb), .code_out(code_out), .cal_done(cal_done)
  );

  typedef struct {
    logic          stb;
    logic [CW-1:0] code;
    logic          cal;
    logic          act;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state, from the requirements
  int cyc, last_upd, quiet_n;
  logic [CW-1:0] code_exp;
  logic prev_stb;

  task automatic model_reset();
    cyc = 0; last_upd = -1; quiet_n = 0; code_exp = RCODE;
  endtask

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // R1: checks while reset is held and right after reset edges
  task automatic do_reset();
    rst = 1'b1; out_active = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++; if (upd_stb !== 1'b0)  fail("R1", "stb in reset", upd_stb, 0);
    checks++; if (cal_done !== 1'b0) fail("R1", "cal in reset", cal_done, 0);
    checks++; if (code_out !== RCODE) fail("R1", "code in reset", code_out, RCODE);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Driver: one cycle, called at a negedge
  task automatic step(logic act, logic [CW-1:0] c, string tag);
    exp_t e;
    out_active = act; code_in = c;
    e.stb  = ((cyc - last_upd) >= GAP) && !act;
    e.code = code_exp;
    e.cal  = (quiet_n >= CAL);
    e.act  = act;
    e.tag  = tag;
    sb.push_back(e);
    @(posedge clk);
    if (e.stb) begin last_upd = cyc; code_exp = c; end
    if (!act) quiet_n++;
    cyc++;
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    exp_t e;
    prev_stb = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (upd_stb !== e.stb) begin
          if (e.stb)      fail("R4", {e.tag, " strobe missing"}, upd_stb, 1);
          else if (e.act) fail("R3", {e.tag, " strobe on busy cycle"}, upd_stb, 0);
          else            fail("R2", {e.tag, " strobe too early"}, upd_stb, 0);
        end
        checks++;
        if (prev_stb && upd_stb) fail("R5", {e.tag, " strobe wider than one cycle"}, 1, 0);
        checks++;
        if (code_out !== e.code) fail("R6", {e.tag, " code"}, code_out, e.code);
        checks++;
        if (cal_done !== e.cal)  fail("R7", {e.tag, " calibrated"}, cal_done, e.cal);
        prev_stb = upd_stb;
      end else prev_stb = 1'b0;
    end
  end

  // Watchdog
  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    do_reset();
    // R8: busy cycles from release still count toward the first interval
    for (int i = 0; i < 20; i++) step(1'b1, CW'(i), "R8 busy start");
    for (int i = 0; i < 80; i++) step(1'b0, CW'(i * 7 + 3), "R2 idle periodic");
    // R4: a busy burst longer than the interval, then the first quiet cycle
    for (int i = 0; i < 45; i++) step(1'b1, CW'(i), "R4 long busy");
    step(1'b0, 6'd21, "R4 first quiet");
    for (int i = 0; i < 31; i++) step(1'b0, CW'(i + 9), "R2 boundary");
    step(1'b1, 6'd5, "R3 busy at limit");
    step(1'b1, 6'd6, "R3 busy at limit");
    step(1'b0, 6'd44, "R4 after limit");
    // Mixed traffic until calibration is reached and beyond
    for (int i = 0; i < 2200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], lfsr[CW-1:0], "R7 mixed");
    end
    // R1: reset in mid-run clears calibration and code
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b0, CW'(i + 1), "R1 after reset");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule